// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block turns the observable state of a UART with transmit and receive FIFOs into interrupt requests. It watches the fill level of each FIFO, a one-cycle strobe for every character written into the receive FIFO, a one-cycle tick per bit period, and the clear-to-send modem input. From these it produces four separate request lines and one combined line. The combined line is the OR of the four.

The two FIFO requests and the receive-silence request are level type. Each one follows its condition and falls away as soon as software or the hardware removes the cause. The clear-to-send request is edge type. Every change of the synchronized CTS input latches it, and it stays set until software asks for a clear.

Each source has an enable bit. A small read port returns either the raw or the masked request vector, so software can poll a source without letting it interrupt.

Top module: `uart_irq_gen`

## Requirements
- R1: The raw TX request (vector bit 0) is 1 in the cycle after the clock edge at which `tx_level` was at most DEPTH/2. It is 0 in the cycle after an edge at which `tx_level` was above DEPTH/2.
- R2: The raw RX request (vector bit 1) is 1 in the cycle after the clock edge at which `rx_level` was at least DEPTH/2 (8 of 16). It is 0 in the cycle after an edge at which `rx_level` was below DEPTH/2.
- R3: The raw RX-timeout request (vector bit 2) is 1 while `rx_level` is nonzero and TIMEOUT_BITS `bit_tick` pulses (32 by default) have been counted since the counter last restarted. It is 0 otherwise.
- R4: The silence counter restarts at every clock edge where `rx_strobe` is 1 or `rx_level` is 0. It saturates at TIMEOUT_BITS.
- R5: `cts_in` passes through two synchronizing flops. A change of `cts_in` first sampled at edge k sets the raw status request (vector bit 3) after edge k+2.
- R6: `status_clear` at an edge clears the latched status request, unless a new synchronized CTS change is detected at that same edge. In that case the request stays set.
- R7: Each request output equals its raw request ANDed with its bit of `irq_enable` (bit 0 TX, bit 1 RX, bit 2 RX-timeout, bit 3 status). Raw status is unaffected by `irq_enable`.
- R8: `irq_any` is the OR of the four masked request outputs.
- R9: `rd_data` returns the raw vector when `rd_sel` is 0 and the masked vector when `rd_sel` is 1, with the bit order of R7.
- R10: After a synchronous active-low reset with `cts_in` held low, every request, the counter and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | 5 | Entries held in the transmit FIFO (0..16) |
| rx_level | input | 5 | Entries held in the receive FIFO (0..16) |
| rx_strobe | input | 1 | One-cycle pulse per received character |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| irq_enable | input | 4 | Per-source enable, bit order of R7 |
| status_clear | input | 1 | Clears the latched status request |
| rd_sel | input | 1 | 0 reads raw status, 1 reads masked status |
| rd_data | output | 4 | Selected status vector |
| irq_tx | output | 1 | Masked TX request |
| irq_rx | output | 1 | Masked RX request |
| irq_rxto | output | 1 | Masked RX-timeout request |
| irq_status | output | 1 | Masked CTS-change request |
| irq_any | output | 1 | OR of the masked requests |

## Verification
The FIFO levels are swept through every value from empty to full. This separates the at-most-half and at-least-half thresholds from off-by-one neighbours.

The timeout is tried in three ways:
- with ticks and no strobes until saturation;
- with a strobe arriving just before the limit;
- with the FIFO emptied mid-count.

These patterns show that the counter restarts on the two distinct causes and stops while the FIFO is empty.

CTS is toggled in both directions with isolated clears and with a clear that coincides with a fresh edge. This tells edge latching apart from a level follower and confirms the precedence of set over clear. The enable vector and the read selector are varied so that raw and masked views diverge.

// File: rtl/uart_irq_pkg.sv
// Package: shared request-vector type for the UART interrupt generator.
// Bit order is fixed: 0 TX, 1 RX, 2 RX-timeout, 3 CTS status.
package uart_irq_pkg;
    localparam int IRQ_N = 4;

    typedef struct packed {
        logic ms;
        logic rxto;
        logic rx;
        logic tx;
    } irq_vec_t;
endpackage

// File: rtl/uart_irq_level.sv
// Module: uart_irq_level
// Registers the two FIFO threshold requests. TX asks for data while the
// transmit FIFO holds at most half its depth; RX asks while the receive
// FIFO holds at least half. Assumes level inputs are synchronous to clk.
module uart_irq_level #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic             tx_raw,
    output logic             rx_raw
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

    // Sample both threshold comparisons once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_raw <= 1'b0;
            rx_raw <= 1'b0;
        end else begin
            tx_raw <= (tx_level <= HALF);
            rx_raw <= (rx_level >= HALF);
        end
    end

    // R1
    tx_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tx_raw == $past(tx_level <= HALF)));
    // R2
    rx_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_raw == $past(rx_level >= HALF)));
endmodule

// File: rtl/uart_irq_rxto.sv
// Module: uart_irq_rxto
// Counts bit periods of receive silence. The count restarts on each
// received character and whenever the receive FIFO is empty, and
// saturates at TIMEOUT_BITS. The request is high at saturation while
// the FIFO still holds data. Assumes bit_tick is a one-cycle pulse.
module uart_irq_rxto #(
    parameter int LVL_W        = 5,
    parameter int TIMEOUT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_strobe,
    input  logic             bit_tick,
    output logic             rxto_raw
);
    localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_BITS);

    logic [CNT_W-1:0] sil_cnt;
    logic             rx_empty;

    assign rx_empty = (rx_level == '0);

    // Advance, restart or hold the silence count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sil_cnt <= '0;
        end else if (rx_strobe || rx_empty) begin
            sil_cnt <= '0;
        end else if (bit_tick && (sil_cnt != LIMIT)) begin
            sil_cnt <= sil_cnt + 1'b1;
        end
    end

    // Request while saturated and data is waiting.
    always_comb begin
        rxto_raw = (sil_cnt == LIMIT) && !rx_empty;
    end

    // R4
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe || rx_empty) |=> (sil_cnt == '0));
    // R4
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sil_cnt == LIMIT && !rx_strobe && !rx_empty) |=> (sil_cnt == LIMIT));
endmodule

// File: rtl/uart_irq_cts.sv
// Module: uart_irq_cts
// Synchronizes the asynchronous CTS input through two flops, detects
// any change, and latches a status request until cleared. A detected
// change wins over a clear in the same cycle.
module uart_irq_cts (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_in,
    input  logic status_clear,
    output logic ms_raw
);
    logic sync_a, sync_b, cts_prev;
    logic cts_edge;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            cts_prev <= 1'b0;
        end else begin
            sync_a   <= cts_in;
            sync_b   <= sync_a;
            cts_prev <= sync_b;
        end
    end

    assign cts_edge = sync_b ^ cts_prev;

    // Latch on change, clear on request, change has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_raw <= 1'b0;
        end else if (cts_edge) begin
            ms_raw <= 1'b1;
        end else if (status_clear) begin
            ms_raw <= 1'b0;
        end
    end

    // R5
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cts_edge |=> ms_raw);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear && !cts_edge) |=> !ms_raw);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_clear && !cts_edge) |=> (ms_raw == $past(ms_raw)));
endmodule

// File: rtl/uart_irq_gen.sv
// Module: uart_irq_gen (top)
// Combines the FIFO threshold, receive-timeout and CTS-change requests,
// applies the per-source enables, ORs the masked lines into one output
// and offers raw or masked status on a read port.
// Assumes all inputs except cts_in are synchronous to clk.
module uart_irq_gen
    import uart_irq_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int TIMEOUT_BITS = 32,
    parameter int LVL_W        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_strobe,
    input  logic             bit_tick,
    input  logic             cts_in,
    input  logic [IRQ_N-1:0] irq_enable,
    input  logic             status_clear,
    input  logic             rd_sel,
    output logic [IRQ_N-1:0] rd_data,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_rxto,
    output logic             irq_status,
    output logic             irq_any
);
    irq_vec_t         raw_v;
    logic [IRQ_N-1:0] raw_bits;
    logic [IRQ_N-1:0] masked_bits;

    uart_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) level_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_raw   (raw_v.tx),
        .rx_raw   (raw_v.rx)
    );

    uart_irq_rxto #(.LVL_W(LVL_W), .TIMEOUT_BITS(TIMEOUT_BITS)) rxto_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_level  (rx_level),
        .rx_strobe (rx_strobe),
        .bit_tick  (bit_tick),
        .rxto_raw  (raw_v.rxto)
    );

    uart_irq_cts cts_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_in       (cts_in),
        .status_clear (status_clear),
        .ms_raw       (raw_v.ms)
    );

    assign raw_bits = raw_v;

    // Per-source masking, one gate per request.
    for (genvar g = 0; g < IRQ_N; g++) begin : g_mask
        assign masked_bits[g] = raw_bits[g] & irq_enable[g];
    end

    // Drive the individual, combined and read-port outputs.
    always_comb begin
        irq_tx     = masked_bits[0];
        irq_rx     = masked_bits[1];
        irq_rxto   = masked_bits[2];
        irq_status = masked_bits[3];
        irq_any    = |masked_bits;
        rd_data    = rd_sel ? masked_bits : raw_bits;
    end

    // R7
    tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable[0] |-> !irq_tx);
    // R7
    ms_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable[3] |-> !irq_status);
    // R8
    any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (irq_tx || irq_rx || irq_rxto || irq_status));
endmodule

// File: tb/uart_irq_gen_tb.sv
// Bench for uart_irq_gen: a behavioural model advances on every rising
// edge and all outputs are compared with it at every falling edge.
module uart_irq_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tx_level = '0, rx_level = '0;
    logic       rx_strobe = 1'b0, bit_tick = 1'b0, cts_in = 1'b0;
    logic [3:0] irq_enable = '0;
    logic       status_clear = 1'b0, rd_sel = 1'b0;
    logic [3:0] rd_data;
    logic       irq_tx, irq_rx, irq_rxto, irq_status, irq_any;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    uart_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .rx_strobe(rx_strobe), .bit_tick(bit_tick), .cts_in(cts_in),
        .irq_enable(irq_enable), .status_clear(status_clear), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_rxto(irq_rxto), .irq_status(irq_status), .irq_any(irq_any)
    );

    // Behavioural reference state
    bit m_tx, m_rx, m_ms;
    int m_sil;
    bit cts_hist[$];   // synchronized CTS samples, newest at back

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx <= 0; m_rx <= 0; m_ms <= 0; m_sil <= 0;
            cts_hist = '{0, 0, 0};
        end else begin
            bit changed;
            m_tx <= (tx_level <= 8);
            m_rx <= (rx_level >= 8);
            if (rx_strobe || rx_level == 0) m_sil <= 0;
            else if (bit_tick && m_sil < 32) m_sil <= m_sil + 1;
            // seen edge: two-stage delayed sample differs from three-stage
            changed = (cts_hist[1] != cts_hist[0]);
            if (changed) m_ms <= 1;
            else if (status_clear) m_ms <= 0;
            cts_hist.push_back(cts_in);
            void'(cts_hist.pop_front());
        end
    end

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        logic [3:0] raw, msk;
        raw = {m_ms, (m_sil == 32 && rx_level != 0), m_rx, m_tx};
        msk = raw & irq_enable;
        chk("R1", {3'b0, irq_tx}, {3'b0, msk[0]});
        chk("R2", {3'b0, irq_rx}, {3'b0, msk[1]});
        chk("R3", {3'b0, irq_rxto}, {3'b0, msk[2]});
        chk("R5", {3'b0, irq_status}, {3'b0, msk[3]});
        chk("R8", {3'b0, irq_any}, {3'b0, |msk});
        chk("R9", rd_data, rd_sel ? msk : raw);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            rx_strobe    = 1'b0;
            bit_tick     = 1'b0;
            status_clear = 1'b0;
        end
    endtask

    // Pulse bit_tick every fourth cycle, n times.
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step(4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, raw view
        chk("R10", rd_data, 4'b0000);
        rst_n = 1'b1;
        irq_enable = 4'b1111;
        tx_level = 5'd12;
        step(2);
        // R1/R2: sweep every level, both read views
        for (int l = 0; l <= 16; l++) begin
            tx_level = 5'(l);
            rx_level = 5'(16 - l);
            rd_sel = l[0];
            step(2);
        end
        // R7: masks differ from raw; R9 raw view
        irq_enable = 4'b0101;
        rd_sel = 1'b0;
        step(3);
        rd_sel = 1'b1;
        step(3);
        irq_enable = 4'b1111;
        // R3: silence until saturation with data waiting
        tx_level = 5'd16;
        rx_level = 5'd3;
        step(2);
        ticks(34);
        // R4: strobe restarts the count
        rx_strobe = 1'b1;
        step(1);
        ticks(31);
        rx_strobe = 1'b1;
        step(1);
        ticks(33);
        // R4: emptying stops and restarts the count
        rx_level = 5'd0;
        ticks(5);
        rx_level = 5'd2;
        ticks(20);
        rx_level = 5'd0;
        step(1);
        rx_level = 5'd1;
        ticks(33);
        rx_level = 5'd0;
        step(2);
        // R5: rising CTS
        cts_in = 1'b1;
        step(6);
        // R6: plain clear
        status_clear = 1'b1;
        step(3);
        // R5: falling CTS, then clear
        cts_in = 1'b0;
        step(5);
        status_clear = 1'b1;
        step(2);
        // R6: set, then clear arriving with a fresh edge keeps it set
        cts_in = 1'b1;
        step(5);
        cts_in = 1'b0;
        step(2);
        status_clear = 1'b1;
        step(1);
        chk("R6", {3'b0, irq_status}, 4'b0001);
        step(3);
        // R7: status masked while raw stays visible
        irq_enable = 4'b0111;
        rd_sel = 1'b0;
        step(2);
        chk("R7", rd_data & 4'b1000, 4'b1000);
        status_clear = 1'b1;
        step(3);
        // R10: reset again clears everything
        rx_level = 5'd10;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        rd_sel = 1'b0;
        tx_level = 5'd16;
        rx_level = 5'd0;
        @(negedge clk);
        chk("R10", rd_data, 4'b0000);
        step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule